// File: doc/BRIEF.md
# Trace Buffer with Overflow Recovery

This block buffers trace packets on their way from a processor trace pipeline to a trace output port. Two kinds of packet arrive on the input. An instruction packet carries an address. A data packet carries a transferred value. Every packet has an end-of-instruction flag. A data packet sets it on the final transfer of its instruction. An instruction packet sets it when that instruction makes no transfers. The input cannot be stalled, so a packet that finds the buffer full is lost. When that happens the block suspends tracing.

While suspended, the block drops all input until its storage has emptied. It then writes one gap marker as the first entry of the restarted stream. If an instruction was still open at that point, the block keeps dropping packets up to and including the end-of-instruction flag of that instruction. Only after that does it accept input again, starting at the next instruction packet. As a result, no data transfer after a gap is ever attributed to the wrong instruction. Packets lost around the gap are acceptable. Misaligned data is not.

The consumer reads the buffer in first-in first-out order with a valid/ready pair. A one-bit tracing flag shows whether input is currently being accepted.

Top module: `trc_ovf_fifo`

## Requirements
- R1: After a synchronous active-high reset, the buffer is empty, `out_valid` is 0 and `tracing` is 1.
- R2: Accepted packets leave in arrival order with kind, flag and payload unchanged. `out_valid` is 1 exactly when the buffer holds an entry. An entry is removed on a clock edge where `out_valid` and `out_ready` are both 1. A head that is not taken stays stable.
- R3: While tracing, a packet that arrives when the buffer holds DEPTH entries is dropped, and the block becomes suspended. This applies even if a read happens in the same cycle. `tracing` reads 0 from the next cycle on.
- R4: While suspended, every incoming packet is dropped. The block stays suspended until the buffer is empty.
- R5: In a suspended cycle that begins with an empty buffer, the block writes exactly one marker entry and drops that cycle's input. The marker is visible at the output in the next cycle.
- R6: An instruction is open when the most recent input packet, accepted or not, had its end flag clear. If an instruction is open after the marker cycle, the block drops all packets up to and including the next packet whose end flag is set. `tracing` stays 0 during this phase and returns to 1 after that packet.
- R7: If no instruction is open after the marker cycle, `tracing` returns to 1 in the next cycle and the following input is accepted.
- R8: Output kind encoding is 0 for an instruction, 1 for data and 2 for the marker. A marker has payload 0 and its end flag set. Input kind is `in_is_data` (0 instruction, 1 data).
- R9: The first entry read after a marker is never a data packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet present on the input this cycle |
| in_is_data | input | 1 | 1 for a data packet, 0 for an instruction packet |
| in_last | input | 1 | End-of-instruction flag |
| in_payload | input | DW | Address or transferred value |
| out_ready | input | 1 | Consumer takes the head entry |
| out_valid | output | 1 | Head entry present |
| out_kind | output | 2 | Head kind: 0 instruction, 1 data, 2 marker |
| out_last | output | 1 | Head end-of-instruction flag |
| out_payload | output | DW | Head payload |
| tracing | output | 1 | 1 while input is being accepted |

## Verification
Every accepted packet, drop decision and marker write takes effect at the clock edge that samples the input. The head of the buffer and the `tracing` flag therefore reflect it one cycle later. A marker shows up one cycle after the suspended cycle in which the buffer was found empty. The bench drives its inputs at the falling edge and advances a cycle-level model of queue contents, suspend state and open-instruction state for the coming rising edge. At the next falling edge it compares the ports against that model, so each result is checked exactly in the cycle it is due.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    K_INSTR = 2'd0,
    K_DATA  = 2'd1,
    K_MARK  = 2'd2
  } pkt_kind_e;

  typedef enum logic [1:0] {
    S_RUN  = 2'd0,
    S_HOLD = 2'd1,
    S_SKIP = 2'd2
  } trc_state_e;

  localparam int KIND_W = 2;
endpackage

// File: rtl/trc_ring.sv
module trc_ring #(
  parameter int DEPTH = 16,
  parameter int PW    = 35,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_word,
  input  logic          rd_en,
  output logic [PW-1:0] rd_word,
  output logic [CW-1:0] occ,
  output logic          is_empty,
  output logic          is_full
);
  logic [PW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
    end
  end

  assign rd_word  = mem[rd_ptr];
  assign is_empty = (occ == '0);
  assign is_full  = (occ == CW'(DEPTH));
endmodule

// File: rtl/trc_ovf_ctl.sv
module trc_ovf_ctl
  import trc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_last,
  input  logic       is_full,
  input  logic       is_empty,
  output logic       accept,
  output logic       mark,
  output logic       tracing,
  output logic [1:0] state_o
);
  trc_state_e st_q, st_nx;
  logic       open_q, open_nx;

  always_comb begin
    open_nx = in_valid ? !in_last : open_q;
    st_nx   = st_q;
    accept  = 1'b0;
    mark    = 1'b0;
    case (st_q)
      S_RUN: begin
        if (in_valid) begin
          if (is_full) st_nx = S_HOLD;
          else         accept = 1'b1;
        end
      end
      S_HOLD: begin
        if (is_empty) begin
          mark  = 1'b1;
          st_nx = open_nx ? S_SKIP : S_RUN;
        end
      end
      S_SKIP: begin
        if (in_valid && in_last) st_nx = S_RUN;
      end
      default: st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_RUN;
      open_q  <= 1'b0;
      tracing <= 1'b1;
    end else begin
      st_q    <= st_nx;
      open_q  <= open_nx;
      tracing <= (st_nx == S_RUN);
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/trc_ovf_fifo.sv
module trc_ovf_fifo
  import trc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int PW   = DW + KIND_W + 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_is_data,
  input  logic          in_last,
  input  logic [DW-1:0] in_payload,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [1:0]    out_kind,
  output logic          out_last,
  output logic [DW-1:0] out_payload,
  output logic          tracing
);
  logic          accept, mark, is_full, is_empty;
  logic          wr_en, rd_en;
  logic [PW-1:0] wr_word, rd_word;
  logic [CW-1:0] occ;
  logic [1:0]    ctl_state;
  pkt_kind_e     in_kind;

  trc_ovf_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .is_full  (is_full),
    .is_empty (is_empty),
    .accept   (accept),
    .mark     (mark),
    .tracing  (tracing),
    .state_o  (ctl_state)
  );

  assign in_kind = in_is_data ? K_DATA : K_INSTR;
  assign wr_en   = accept | mark;
  assign wr_word = mark ? {K_MARK, 1'b1, {DW{1'b0}}}
                        : {in_kind, in_last, in_payload};
  assign rd_en   = out_ready && !is_empty;

  trc_ring #(.DEPTH(DEPTH), .PW(PW)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .rd_en    (rd_en),
    .rd_word  (rd_word),
    .occ      (occ),
    .is_empty (is_empty),
    .is_full  (is_full)
  );

  assign out_valid   = !is_empty;
  assign out_kind    = rd_word[PW-1 -: KIND_W];
  assign out_last    = rd_word[DW];
  assign out_payload = rd_word[DW-1:0];
endmodule

// File: rtl/trc_ovf_fifo_chk.sv
module trc_ovf_fifo_chk
  import trc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_last,
  input logic          out_ready,
  input logic          out_valid,
  input logic [1:0]    out_kind,
  input logic [DW-1:0] out_payload,
  input logic          tracing,
  input logic [CW-1:0] occ,
  input logic [1:0]    st
);
  // R2
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_payload)));

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && in_valid && occ == CW'(DEPTH)) |=> (st == S_HOLD && !tracing));

  // R4
  hold_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && occ != '0) |=> (st == S_HOLD && occ <= $past(occ)));

  // R5
  marker_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && occ == '0) |=> (out_valid && out_kind == K_MARK && occ == CW'(1)));

  // R6
  skip_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_SKIP && !(in_valid && in_last)) |=> (st == S_SKIP && !tracing && occ <= $past(occ)));

  // R8
  kind_code_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_kind != 2'd3));
endmodule

bind trc_ovf_fifo trc_ovf_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_last     (in_last),
  .out_ready   (out_ready),
  .out_valid   (out_valid),
  .out_kind    (out_kind),
  .out_payload (out_payload),
  .tracing     (tracing),
  .occ         (occ),
  .st          (ctl_state)
);

// File: tb/trc_ovf_fifo_bench.sv
`timescale 1ns/1ps
module trc_ovf_fifo_bench;
  localparam int DEPTH = 16;
  localparam int DW    = 32;
  localparam int EW    = DW + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_is_data = 1'b0, in_last = 1'b0;
  logic [DW-1:0] in_payload = '0;
  logic          out_ready = 1'b0;
  logic          out_valid, out_last, tracing;
  logic [1:0]    out_kind;
  logic [DW-1:0] out_payload;

  always #2.5 clk = ~clk;

  trc_ovf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_trc_ovf_fifo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_data(in_is_data),
    .in_last(in_last), .in_payload(in_payload), .out_ready(out_ready),
    .out_valid(out_valid), .out_kind(out_kind), .out_last(out_last),
    .out_payload(out_payload), .tracing(tracing)
  );

  int n_vec = 0, n_bad = 0;
  // model: 0 running, 1 suspended, 2 skipping
  int            ms = 0, prev_ms = 0;
  bit            mopen = 0;
  logic [EW-1:0] mq[$];
  int            rem = 0;
  logic [DW-1:0] next_addr = 32'h1000;
  bit            mark_seen = 0;

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string trace_tag();
    if (ms == 1) return "R4";
    if (ms == 2) return "R6";
    if (prev_ms == 1) return "R7";
    return "R3";
  endfunction

  task automatic step(input int rdy_pct, input int vld_pct);
    bit iv, idat, ilast, ordy, pop, full;
    logic [DW-1:0] ipay;
    @(negedge clk);
    check(trace_tag(), "tracing", 64'(tracing), 64'(ms == 0));
    check("R2", "out_valid", 64'(out_valid), 64'(mq.size() > 0));
    if (mq.size() > 0 && out_valid)
      check((mq[0][EW-1 -: 2] == 2'd2) ? "R5/R8" : "R2", "head",
            64'({out_kind, out_last, out_payload}), 64'(mq[0]));
    // choose stimulus
    iv = ($urandom % 100) < vld_pct;
    ordy = ($urandom % 100) < rdy_pct;
    idat = 0; ilast = 0; ipay = '0;
    if (iv) begin
      if (rem == 0) begin
        rem = $urandom % 5;
        idat = 0; ilast = (rem == 0); ipay = next_addr;
        next_addr = next_addr + 32'd4;
      end else begin
        rem--;
        idat = 1; ilast = (rem == 0); ipay = $urandom;
      end
    end
    in_valid = iv; in_is_data = idat; in_last = ilast; in_payload = ipay;
    out_ready = ordy;
    // R9: entry following a marker as it is read from the port
    if (out_valid && ordy) begin
      if (mark_seen && out_kind != 2'd2) begin
        check("R9", "kind after marker is data", 64'(out_kind == 2'd1), 64'd0);
        mark_seen = 0;
      end
      if (out_kind == 2'd2) mark_seen = 1;
    end
    // model update for the coming edge
    prev_ms = ms;
    full = (mq.size() == DEPTH);
    pop  = ordy && (mq.size() > 0);
    if (pop) void'(mq.pop_front());
    case (ms)
      0: if (iv) begin
           if (full) ms = 1;
           else mq.push_back({1'b0, idat, ilast, ipay});
         end
      1: if (pop == 0 && mq.size() == 0) begin
           mq.push_back({2'd2, 1'b1, {DW{1'b0}}});
           ms = (iv ? !ilast : mopen) ? 2 : 0;
         end
      default: if (iv && ilast) ms = 0;
    endcase
    if (iv) mopen = !ilast;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "out_valid after reset", 64'(out_valid), 64'd0);
    check("R1", "tracing after reset", 64'(tracing), 64'd1);
    for (int i = 0; i < 800; i++)  step(90, 70);
    for (int i = 0; i < 1500; i++) step(15, 85);
    // directed: stalled reader forces an overflow, then full drain
    for (int i = 0; i < 24; i++)   step(0, 100);
    for (int i = 0; i < 40; i++)   step(100, 100);
    for (int i = 0; i < 24; i++)   step(0, 100);
    for (int i = 0; i < 40; i++)   step(100, 30);
    for (int i = 0; i < 1500; i++) step(50, 70);
    for (int i = 0; i < 60; i++)   step(100, 0);
    @(negedge clk);
    check("R2", "drained at end", 64'(out_valid), 64'(mq.size() > 0));
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule